// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block puts a small word-addressed memory behind several request ports and gives each port the two-step atomic primitive used to build locks and counters in software. A requester first issues a load-linked, which returns the current word and places a reservation (a valid flag and an address) for that requester. The requester may then compute a new value and issue a store-conditional to the same address. The store-conditional writes only if no other requester has written that word in the meantime. A flag reports whether it succeeded, so software can retry the sequence when it fails.

Each requester holds at most one reservation. Any write that lands on a reserved address, from a plain store or from a successful store-conditional of another requester, clears that reservation. A fixed-priority arbiter grants one operation per cycle to the lowest-numbered requester with a pending request. The granted operation completes in that cycle, and its result appears one cycle later, marked by a strobe on that requester's response-valid bit. A requester holds its request until it sees its strobe and then drops it.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no response is valid, every memory word reads as zero and no reservation exists, so a store-conditional issued before any load-linked fails.
- R2: Arbitration is fixed priority with the lowest index first, and one operation is granted per cycle. The granted requester's bit of `rsp_valid` is set alone in the following cycle, and a requester with no pending request never receives a strobe.
- R3: Operation code 0 (load) returns the addressed word. Operation code 1 (store) writes `wdata` to the addressed word and reports `rsp_ok`=1. For every operation, `rsp_data` is the value the word held before the operation.
- R4: Operation code 2 (load-linked) returns the word, reports `rsp_ok`=1, and records a reservation on that address for the issuer.
- R5: Operation code 3 (store-conditional) succeeds when the issuer holds a valid reservation on the same address. It then writes `wdata` and reports `rsp_ok`=1.
- R6: A failed store-conditional reports `rsp_ok`=0, leaves memory unchanged and leaves every other requester's reservation unchanged.
- R7: A write by another requester to a reserved address clears that reservation. A write to a different address does not clear it, and a plain store by the reservation's own holder does not clear it either.
- R8: Every store-conditional, successful or not, consumes the issuer's reservation, so a second store-conditional without a new load-linked fails.
- R9: A new load-linked replaces the issuer's earlier reservation, so a store-conditional to the earlier address fails.
- R10: When two requesters present store-conditionals to the same reserved address in the same cycle, the lower index succeeds and the higher one, served afterwards, fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NREQ | Per-requester request pending, held until the matching strobe |
| req_op | input | 2*NREQ | Per-requester operation code (0 load, 1 store, 2 load-linked, 3 store-conditional) |
| req_addr | input | AW*NREQ | Per-requester word address |
| req_wdata | input | DW*NREQ | Per-requester write data |
| rsp_valid | output | NREQ | One-hot completion strobe, one cycle after the grant |
| rsp_data | output | DW | Word value before the completed operation |
| rsp_ok | output | 1 | 1 unless the completed operation was a failed store-conditional |

## Verification
Two functions can coincide in one cycle: arbitration between competing requesters, and the reservation check of a store-conditional. The bench provokes this by presenting store-conditionals from two requesters that both hold a reservation on one address in the same cycle. It also presents plain loads from two requesters at once. A reference model applies the operations in priority order. The scoreboard expects the lower index to be served first and succeed, and the higher index to be served next and fail because the first write cleared its reservation. Memory is then read back to confirm that only the winner's value landed.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LINK  = 2'd2,
    OP_COND  = 2'd3
  } llsc_op_e;
endpackage

// File: rtl/llsc_prio_arb.sv
module llsc_prio_arb #(
  parameter int NREQ = 4,
  localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic [NREQ-1:0] req,
  output logic [NREQ-1:0] gnt,
  output logic [IW-1:0]   gnt_idx,
  output logic            any
);
  logic [NREQ:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < NREQ; i++) begin : g_chain
    assign gnt[i]         = req[i] & ~blocked[i];
    assign blocked[i + 1] = blocked[i] | req[i];
  end

  assign any = blocked[NREQ];

  always_comb begin
    gnt_idx = '0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (req[i]) gnt_idx = IW'(i);
    end
  end
endmodule

// File: rtl/llsc_resv_table.sv
module llsc_resv_table #(
  parameter int NREQ = 4,
  parameter int AW   = 4,
  localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] op_idx,
  input  logic [AW-1:0] op_addr,
  input  logic          link_set,
  input  logic          cond_done,
  input  logic          word_we,
  output logic          hit
);
  logic [NREQ-1:0] rv;
  logic [AW-1:0]   ra [NREQ];

  for (genvar i = 0; i < NREQ; i++) begin : g_slot
    logic mine;
    assign mine = (op_idx == IW'(i));
    always_ff @(posedge clk) begin
      if (rst) begin
        rv[i] <= 1'b0;
        ra[i] <= '0;
      end else if (link_set && mine) begin
        rv[i] <= 1'b1;
        ra[i] <= op_addr;
      end else if (cond_done && mine) begin
        rv[i] <= 1'b0;
      end else if (word_we && !mine && ra[i] == op_addr) begin
        rv[i] <= 1'b0;
      end
    end
  end

  assign hit = rv[op_idx] && (ra[op_idx] == op_addr);
endmodule

// File: rtl/llsc_word_mem.sv
module llsc_word_mem #(
  parameter int AW = 4,
  parameter int DW = 32,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] words [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) words[w] <= '0;
      else if (we && addr == AW'(w)) words[w] <= wdata;
    end
  end

  assign rdata = words[addr];
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int NREQ = 4,
  parameter int AW   = 4,
  parameter int DW   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NREQ-1:0]    req_valid,
  input  logic [2*NREQ-1:0]  req_op,
  input  logic [AW*NREQ-1:0] req_addr,
  input  logic [DW*NREQ-1:0] req_wdata,
  output logic [NREQ-1:0]    rsp_valid,
  output logic [DW-1:0]      rsp_data,
  output logic               rsp_ok
);
  import llsc_pkg::*;
  localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1;

  logic [NREQ-1:0] gnt;
  logic [IW-1:0]   gidx;
  logic            gany;
  llsc_op_e        sel_op;
  logic [AW-1:0]   sel_addr;
  logic [DW-1:0]   sel_wdata;
  logic            resv_hit;
  logic            mem_we;
  logic [DW-1:0]   mem_rd;

  llsc_prio_arb #(.NREQ(NREQ)) u_arb (
    .req(req_valid), .gnt(gnt), .gnt_idx(gidx), .any(gany)
  );

  always_comb begin
    sel_op    = llsc_op_e'(req_op[gidx*2 +: 2]);
    sel_addr  = req_addr[gidx*AW +: AW];
    sel_wdata = req_wdata[gidx*DW +: DW];
  end

  assign mem_we = gany && ((sel_op == OP_STORE) || (sel_op == OP_COND && resv_hit));

  llsc_resv_table #(.NREQ(NREQ), .AW(AW)) u_resv (
    .clk(clk), .rst(rst), .op_idx(gidx), .op_addr(sel_addr),
    .link_set(gany && sel_op == OP_LINK),
    .cond_done(gany && sel_op == OP_COND),
    .word_we(mem_we), .hit(resv_hit)
  );

  llsc_word_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst(rst), .we(mem_we), .addr(sel_addr),
    .wdata(sel_wdata), .rdata(mem_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= '0;
      rsp_data  <= '0;
      rsp_ok    <= 1'b0;
    end else begin
      rsp_valid <= gnt;
      if (gany) begin
        rsp_data <= mem_rd;
        rsp_ok   <= (sel_op != OP_COND) || resv_hit;
      end
    end
  end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int NREQ = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [NREQ-1:0] req_valid,
  input logic [NREQ-1:0] rsp_valid,
  input logic            rsp_ok,
  input logic            mem_we,
  input logic [1:0]      sel_op
);
  p_onehot_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rsp_valid));

  p_lowest_first_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid[0] |=> rsp_valid[0]);

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> rsp_valid == '0);

  p_fail_no_write_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid != '0 && !rsp_ok && !$past(rst)) |-> !$past(mem_we));

  p_fail_only_cond_r5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid != '0 && !rsp_ok && !$past(rst)) |-> $past(sel_op) == 2'd3);

  for (genvar i = 0; i < NREQ; i++) begin : g_src
    p_strobe_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid[i] && !$past(rst)) |-> $past(req_valid[i]));
  end
endmodule

bind llsc_monitor llsc_monitor_chk #(.NREQ(NREQ)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_ok(rsp_ok), .mem_we(mem_we), .sel_op(sel_op)
);

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb;
  localparam int NREQ = 4;
  localparam int AW   = 4;
  localparam int DW   = 32;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [NREQ-1:0]    req_valid = '0;
  logic [2*NREQ-1:0]  req_op = '0;
  logic [AW*NREQ-1:0] req_addr = '0;
  logic [DW*NREQ-1:0] req_wdata = '0;
  logic [NREQ-1:0]    rsp_valid;
  logic [DW-1:0]      rsp_data;
  logic               rsp_ok;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  llsc_monitor #(.NREQ(NREQ), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_ok(rsp_ok)
  );

  // reference model
  logic [DW-1:0] m_mem [1 << AW];
  logic          m_rv  [NREQ];
  int            m_ra  [NREQ];

  // scoreboard
  int            q_idx [$];
  logic [DW-1:0] q_data[$];
  logic          q_ok  [$];
  string         q_tag [$];

  task automatic model_push(input int i, input int op, input int a,
                            input logic [DW-1:0] d, input string tag);
    logic ok;
    logic hit;
    logic wr;
    hit = m_rv[i] && m_ra[i] == a;
    ok  = (op != 3) || hit;
    wr  = (op == 1) || (op == 3 && hit);
    q_idx.push_back(i);
    q_data.push_back(m_mem[a]);
    q_ok.push_back(ok);
    q_tag.push_back(tag);
    if (op == 2) begin
      m_rv[i] = 1'b1;
      m_ra[i] = a;
    end else if (op == 3) begin
      m_rv[i] = 1'b0;
    end
    if (wr) begin
      m_mem[a] = d;
      for (int k = 0; k < NREQ; k++)
        if (k != i && m_ra[k] == a) m_rv[k] = 1'b0;
    end
  endtask

  task automatic drive(input int i, input int op, input int a, input logic [DW-1:0] d);
    req_valid[i]           = 1'b1;
    req_op[i*2 +: 2]       = 2'(op);
    req_addr[i*AW +: AW]   = AW'(a);
    req_wdata[i*DW +: DW]  = d;
  endtask

  task automatic issue(input int i, input int op, input int a,
                       input logic [DW-1:0] d, input string tag);
    @(negedge clk);
    model_push(i, op, a, d, tag);
    drive(i, op, a, d);
    @(negedge clk);
    req_valid[i] = 1'b0;
  endtask

  // i < j: both presented together, i served first
  task automatic issue2(input int i, input int opi, input int ai, input logic [DW-1:0] di,
                        input int j, input int opj, input int aj, input logic [DW-1:0] dj,
                        input string tag);
    @(negedge clk);
    model_push(i, opi, ai, di, tag);
    model_push(j, opj, aj, dj, tag);
    drive(i, opi, ai, di);
    drive(j, opj, aj, dj);
    @(negedge clk);
    req_valid[i] = 1'b0;
    @(negedge clk);
    req_valid[j] = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid != '0) begin
      int got;
      got = -1;
      for (int k = 0; k < NREQ; k++) if (rsp_valid[k]) got = k;
      checks++;
      if (q_idx.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected strobe: actual idx=%0d expected none", got);
      end else begin
        int ei;
        logic [DW-1:0] ed;
        logic eo;
        string tg;
        ei = q_idx.pop_front();
        ed = q_data.pop_front();
        eo = q_ok.pop_front();
        tg = q_tag.pop_front();
        if (got != ei || rsp_data !== ed || rsp_ok !== eo) begin
          errors++;
          $display("FAIL %s: actual idx=%0d data=%h ok=%b expected idx=%0d data=%h ok=%b",
                   tg, got, rsp_data, rsp_ok, ei, ed, eo);
        end
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    for (int w = 0; w < (1 << AW); w++) m_mem[w] = '0;
    for (int k = 0; k < NREQ; k++) begin
      m_rv[k] = 1'b0;
      m_ra[k] = -1;
    end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    checks++;
    if (rsp_valid !== '0) begin
      errors++;
      $display("FAIL R1 reset strobe: actual %b expected 0", rsp_valid);
    end

    issue(1, 0, 5, 0, "R1 load after reset");
    issue(2, 3, 5, 32'hdead, "R1 cond without link");
    issue(0, 1, 5, 32'h11, "R3 store");
    issue(3, 0, 5, 0, "R3 load back");

    issue(1, 2, 5, 0, "R4 link");
    issue(1, 3, 5, 32'h22, "R5 cond success");
    issue(1, 3, 5, 32'h33, "R8 second cond");
    issue(2, 0, 5, 0, "R6 memory after fail");

    issue(2, 2, 7, 0, "R4 link");
    issue(0, 1, 7, 32'h44, "R7 foreign store");
    issue(2, 3, 7, 32'h55, "R7 cond after foreign store");
    issue(0, 0, 7, 0, "R6 memory after fail");

    issue(3, 2, 8, 0, "R4 link");
    issue(0, 1, 9, 32'h66, "R7 store elsewhere");
    issue(3, 3, 8, 32'h77, "R7 cond after unrelated store");

    issue(1, 2, 2, 0, "R4 link");
    issue(1, 1, 2, 32'h88, "R7 own store");
    issue(1, 3, 2, 32'h99, "R7 cond after own store");

    issue(2, 2, 3, 0, "R9 first link");
    issue(2, 2, 4, 0, "R9 second link");
    issue(2, 3, 3, 32'haa, "R9 cond old address");
    issue(2, 3, 4, 32'hbb, "R9 cond new address");

    issue(1, 2, 6, 0, "R4 link");
    issue(3, 2, 6, 0, "R4 link");
    issue2(1, 3, 6, 32'hc1, 3, 3, 6, 32'hc3, "R10 racing conds");
    issue(0, 0, 6, 0, "R10 winner value");

    issue2(0, 0, 8, 0, 2, 0, 9, 0, "R2 concurrent loads");

    issue(0, 2, 10, 0, "R4 link");
    issue(1, 2, 10, 0, "R4 link");
    issue(2, 3, 10, 32'hee, "R6 stray cond");
    issue(0, 3, 10, 32'hf0, "R6 others kept");
    issue(1, 3, 10, 32'hf1, "R7 cleared by winner");
    issue(3, 0, 10, 0, "R6 final value");

    repeat (3) @(negedge clk);
    checks++;
    if (q_idx.size() != 0) begin
      errors++;
      $display("FAIL R2 missing responses: actual %0d pending expected 0", q_idx.size());
    end
    finish_run();
  end
endmodule